// File: doc/BRIEF.md
# Multi-Leg PWM Generator with Selectable Duty Latching

This block drives the gates of six half-bridge legs from one shared up/down triangle carrier. Each leg receives a complementary pair of gate signals, high side and low side. A programmable dead time separates the two so that they are never on together. Software writes duty values into per-leg shadow registers. A latch-mode setting decides when all shadows move together into the active compare registers. The choices are every clock (immediate), at the next carrier peak or valley, or at the next pulse on an external timing trigger. The trigger usually comes from a sub-rate sequencer, so duty changes line up with sampling and control execution.

Each leg has its own enable bit and its own polarity-invert bit. A disabled leg holds both gates low. An inverted leg swaps the roles of its two gates. The carrier also produces one-cycle peak and valley strobes that the rest of the system can use.

Top module: `multi_leg_pwm`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, every gate output and both strobes are low. Reset clears the carrier to 0 (counting up) and clears all registers: period, dead time, mode, enable mask, invert mask and duties.
- R2: With a period P ≥ 1 written at address 8, the carrier counts 0,1,…,P,P−1,…,0 and repeats. `peak_stb` is high for the one cycle the carrier holds P on the way up. `valley_stb` is high for the one cycle it holds 0 on the way down. The two strobes are never high together.
- R3: Duty for leg i is written at address i (0…5). Take the cycle in which the carrier value is below that leg's active duty. The leg's high-side request rises on the clock after that cycle, and its low-side request falls on the same clock.
- R4: An active duty at or above the period keeps the high-side request on for the whole carrier cycle. A duty of 0 keeps it off.
- R5: With mode value 0 at address 10 (immediate), the shadows are copied into the active registers on every clock. A duty write therefore reaches the compare one clock after it is written.
- R6: With mode value 1 (extremum), the shadows are copied only on a clock where `peak_stb` or `valley_stb` is high. Writes made in between have no effect on the gates until that clock.
- R7: With mode value 2 or 3 (trigger), the shadows are copied only on a clock where `ext_trig` is high. Carrier extrema do not cause a copy in this mode. In modes 0 and 1, `ext_trig` has no effect.
- R8: All six legs take their new duties on the same clock. Between copy events the active duties do not change.
- R9: Bit i of the enable mask (address 11) low forces both gates of leg i low, whatever the invert bit is.
- R10: Bit i of the invert mask (address 12) high swaps leg i's gates. The high-side pin then carries the low-side request and the low-side pin carries the high-side request.
- R11: After a request change on a leg, both of its gates stay low for D cycles, where D is the dead time at address 9. The new gate then turns on. `gate_hi` and `gate_lo` of one leg are never high together.
- R12: A period of 0 holds the carrier at 0 and produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| ext_trig | input | 1 | External timing trigger pulse |
| gate_hi | output | 6 | High-side gate per leg |
| gate_lo | output | 6 | Low-side gate per leg |
| peak_stb | output | 1 | Carrier peak strobe |
| valley_stb | output | 1 | Carrier valley strobe |

## Verification
The assertions assume that `ext_trig` and register writes are sampled only on the clock edge. The copy checks also assume that the latch mode observed in a cycle is the one that governs that cycle's transfer decision. The carrier checks take for granted that the period is not rewritten in the middle of an observed turnaround. The stimulus therefore drives every input half a cycle away from the active edge and makes one write at a time. It changes the period only in separate phases, and each phase runs long enough for the carrier to pass several full peak and valley cycles before its checks.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    LATCH_NOW      = 2'd0,
    LATCH_EXTREMUM = 2'd1,
    LATCH_TRIG     = 2'd2,
    LATCH_TRIG_ALT = 2'd3
  } latch_mode_e;

  localparam int unsigned REG_PERIOD   = 8;
  localparam int unsigned REG_DEADTIME = 9;
  localparam int unsigned REG_MODE     = 10;
  localparam int unsigned REG_ENABLE   = 11;
  localparam int unsigned REG_INVERT   = 12;

endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_up,
  output logic             peak_evt,
  output logic             valley_evt
);

  function automatic logic at_top(input logic up, input logic [CNT_W-1:0] c,
                                  input logic [CNT_W-1:0] p);
    return up && (p != '0) && (c >= p);
  endfunction

  function automatic logic at_bottom(input logic up, input logic [CNT_W-1:0] c);
    return !up && (c == '0);
  endfunction

  assign peak_evt   = at_top(cnt_up, cnt, period);
  assign valley_evt = at_bottom(cnt_up, cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      cnt_up <= 1'b1;
    end else if (period == '0) begin
      cnt    <= '0;
      cnt_up <= 1'b1;
    end else if (cnt_up) begin
      if (cnt >= period) begin
        cnt_up <= 1'b0;
        cnt    <= cnt - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt == '0) begin
        cnt_up <= 1'b1;
        cnt    <= cnt + 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank #(
  parameter int NUM_LEGS = 6,
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [CNT_W-1:0]                 wr_data,
  input  logic                             load,
  output logic [NUM_LEGS-1:0][CNT_W-1:0]   shadow,
  output logic [NUM_LEGS-1:0][CNT_W-1:0]   active
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (load) begin
        active <= shadow;
      end
      for (int i = 0; i < NUM_LEGS; i++) begin
        if (wr_en && (wr_addr == ADDR_W'(i))) begin
          shadow[i] <= wr_data;
        end
      end
    end
  end

endmodule

// File: rtl/pwm_leg.sv
module pwm_leg #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic [DT_W-1:0]  dead,
  input  logic             enable,
  input  logic             invert,
  output logic             hi,
  output logic             lo
);

  function automatic logic wants_high(input logic [CNT_W-1:0] c,
                                      input logic [CNT_W-1:0] d,
                                      input logic [CNT_W-1:0] p);
    return (d >= p) || (c < d);
  endfunction

  logic            req_now;
  logic            req_q;
  logic [DT_W-1:0] gap_cnt;
  logic            hi_on;
  logic            lo_on;

  assign req_now = wants_high(cnt, duty, period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      gap_cnt <= '0;
    end else begin
      req_q <= req_now;
      if (req_now != req_q) begin
        gap_cnt <= dead;
      end else if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
    end
  end

  assign hi_on = req_q && (gap_cnt == '0);
  assign lo_on = !req_q && (gap_cnt == '0);

  assign hi = enable && (invert ? lo_on : hi_on);
  assign lo = enable && (invert ? hi_on : lo_on);

endmodule

// File: rtl/multi_leg_pwm.sv
module multi_leg_pwm
  import pwm_pkg::*;
#(
  parameter int NUM_LEGS = 6,
  parameter int CNT_W    = 16,
  parameter int DT_W     = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic                ext_trig,
  output logic [NUM_LEGS-1:0] gate_hi,
  output logic [NUM_LEGS-1:0] gate_lo,
  output logic                peak_stb,
  output logic                valley_stb
);

  logic [CNT_W-1:0]               period_q;
  logic [DT_W-1:0]                dead_q;
  latch_mode_e                    mode_q;
  logic [NUM_LEGS-1:0]            enable_q;
  logic [NUM_LEGS-1:0]            invert_q;

  logic [CNT_W-1:0]               carrier_cnt;
  logic                           carrier_up;
  logic                           load_evt;
  logic [NUM_LEGS-1:0][CNT_W-1:0] duty_shadow;
  logic [NUM_LEGS-1:0][CNT_W-1:0] duty_active;

  function automatic logic hit(input logic we, input logic [ADDR_W-1:0] a,
                               input int unsigned target);
    return we && (a == ADDR_W'(target));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      dead_q   <= '0;
      mode_q   <= LATCH_NOW;
      enable_q <= '0;
      invert_q <= '0;
    end else begin
      if (hit(wr_en, wr_addr, REG_PERIOD))   period_q <= wr_data;
      if (hit(wr_en, wr_addr, REG_DEADTIME)) dead_q   <= wr_data[DT_W-1:0];
      if (hit(wr_en, wr_addr, REG_MODE))     mode_q   <= latch_mode_e'(wr_data[1:0]);
      if (hit(wr_en, wr_addr, REG_ENABLE))   enable_q <= wr_data[NUM_LEGS-1:0];
      if (hit(wr_en, wr_addr, REG_INVERT))   invert_q <= wr_data[NUM_LEGS-1:0];
    end
  end

  pwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .period     (period_q),
    .cnt        (carrier_cnt),
    .cnt_up     (carrier_up),
    .peak_evt   (peak_stb),
    .valley_evt (valley_stb)
  );

  always_comb begin
    unique case (mode_q)
      LATCH_NOW:      load_evt = 1'b1;
      LATCH_EXTREMUM: load_evt = peak_stb || valley_stb;
      default:        load_evt = ext_trig;
    endcase
  end

  pwm_duty_bank #(
    .NUM_LEGS (NUM_LEGS),
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load    (load_evt),
    .shadow  (duty_shadow),
    .active  (duty_active)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    pwm_leg #(.CNT_W(CNT_W), .DT_W(DT_W)) u_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (carrier_cnt),
      .period (period_q),
      .duty   (duty_active[g]),
      .dead   (dead_q),
      .enable (enable_q[g]),
      .invert (invert_q[g]),
      .hi     (gate_hi[g]),
      .lo     (gate_lo[g])
    );
  end

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int NUM_LEGS = 6,
  parameter int CNT_W    = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      peak_stb,
  input logic                      valley_stb,
  input logic [NUM_LEGS-1:0]       gate_hi,
  input logic [NUM_LEGS-1:0]       gate_lo,
  input logic [NUM_LEGS-1:0]       enable_q,
  input logic [1:0]                mode_q,
  input logic                      ext_trig,
  input logic                      load_evt,
  input logic [NUM_LEGS*CNT_W-1:0] shadow_flat,
  input logic [NUM_LEGS*CNT_W-1:0] active_flat
);

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(peak_stb && valley_stb));

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0);

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi | gate_lo) & ~enable_q) == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> active_flat == $past(active_flat));

  assert_now_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |=> active_flat == $past(shadow_flat));

  assert_edge_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1 && (peak_stb || valley_stb)) |=> active_flat == $past(shadow_flat));

  assert_trig_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1] && ext_trig) |=> active_flat == $past(shadow_flat));

endmodule

bind multi_leg_pwm pwm_checker #(.NUM_LEGS(NUM_LEGS), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .peak_stb    (peak_stb),
  .valley_stb  (valley_stb),
  .gate_hi     (gate_hi),
  .gate_lo     (gate_lo),
  .enable_q    (enable_q),
  .mode_q      (mode_q),
  .ext_trig    (ext_trig),
  .load_evt    (load_evt),
  .shadow_flat (duty_shadow),
  .active_flat (duty_active)
);

// File: tb/sim_multi_leg_pwm.sv
module sim_multi_leg_pwm;

  localparam int LEGS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ext_trig = 1'b0;
  logic [5:0]  gate_hi, gate_lo;
  logic        peak_stb, valley_stb;

  always #5 clk = ~clk;

  multi_leg_pwm u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_trig(ext_trig), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .peak_stb(peak_stb), .valley_stb(valley_stb)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R3";

  // behavioural reference state
  int m_cnt = 0, m_dir = 1, m_per = 0, m_dead = 0, m_mode = 0, m_en = 0, m_inv = 0;
  int m_sh[LEGS];
  int m_act[LEGS];
  int m_req[LEGS];
  int m_gap[LEGS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_peak();
    return (m_dir == 1 && m_per > 0 && m_cnt >= m_per) ? 1 : 0;
  endfunction

  function automatic int exp_valley();
    return (m_dir == -1 && m_cnt == 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dir = 1; m_per = 0; m_dead = 0; m_mode = 0; m_en = 0; m_inv = 0;
      foreach (m_sh[i]) begin m_sh[i] = 0; m_act[i] = 0; m_req[i] = 0; m_gap[i] = 0; end
    end else begin
      int pk, vl, ld, want;
      pk = exp_peak();
      vl = exp_valley();
      ld = (m_mode == 0) || (m_mode == 1 && (pk || vl)) || (m_mode >= 2 && ext_trig);
      foreach (m_req[i]) begin
        want = (m_act[i] >= m_per || m_cnt < m_act[i]) ? 1 : 0;
        if (want != m_req[i]) m_gap[i] = m_dead;
        else if (m_gap[i] > 0) m_gap[i] = m_gap[i] - 1;
        m_req[i] = want;
      end
      if (m_per == 0) begin m_cnt = 0; m_dir = 1; end
      else if (pk) begin m_dir = -1; m_cnt = m_cnt - 1; end
      else if (vl) begin m_dir = 1; m_cnt = 1; end
      else m_cnt = m_cnt + m_dir;
      if (ld) foreach (m_act[i]) m_act[i] = m_sh[i];
      if (wr_en) begin
        if (wr_addr < LEGS) m_sh[wr_addr] = wr_data;
        else if (wr_addr == 8) m_per = wr_data;
        else if (wr_addr == 9) m_dead = wr_data & 8'hFF;
        else if (wr_addr == 10) m_mode = wr_data & 3;
        else if (wr_addr == 11) m_en = wr_data & 6'h3F;
        else if (wr_addr == 12) m_inv = wr_data & 6'h3F;
      end
    end
  end

  // compare against the model every cycle, half a period from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string sreq;
      sreq = (m_per == 0) ? "R12" : "R2";
      chk(peak_stb == exp_peak(), sreq, peak_stb, exp_peak());
      chk(valley_stb == exp_valley(), sreq, valley_stb, exp_valley());
      for (int i = 0; i < LEGS; i++) begin
        int on_h, on_l, eh, el;
        on_h = (m_req[i] == 1 && m_gap[i] == 0) ? 1 : 0;
        on_l = (m_req[i] == 0 && m_gap[i] == 0) ? 1 : 0;
        if (m_inv[i]) begin eh = on_l; el = on_h; end
        else begin eh = on_h; el = on_l; end
        if (!m_en[i]) begin eh = 0; el = 0; end
        chk(gate_hi[i] == eh, cur_req, gate_hi[i], eh);
        chk(gate_lo[i] == el, cur_req, gate_lo[i], el);
        chk(!(gate_hi[i] && gate_lo[i]), "R11", gate_hi[i] & gate_lo[i], 0);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    run(4);
    chk(gate_hi == 6'h00, "R1", gate_hi, 0);
    chk(gate_lo == 6'h00, "R1", gate_lo, 0);
    chk(peak_stb == 1'b0, "R1", peak_stb, 0);
    chk(valley_stb == 1'b0, "R1", valley_stb, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(gate_hi == 6'h00 && gate_lo == 6'h00, "R1", {gate_hi, gate_lo}, 0);

    cur_req = "R12";
    wr(11, 6'h3F);
    run(20);

    cur_req = "R3";
    wr(9, 2);
    wr(0, 0); wr(1, 4); wr(2, 6); wr(3, 12); wr(4, 20); wr(5, 9);
    wr(8, 12);
    run(80);

    cur_req = "R5";
    wr(1, 8);
    run(3);
    wr(2, 2);
    run(50);

    cur_req = "R4";
    wr(0, 12); wr(1, 0); wr(2, 13); wr(3, 16'hFFFF);
    run(60);

    cur_req = "R6";
    wr(10, 1);
    wr(0, 3); wr(1, 7); wr(2, 11); wr(3, 5); wr(4, 1); wr(5, 10);
    run(60);
    pulse_trig();
    wr(0, 9);
    run(40);

    cur_req = "R7";
    wr(10, 2);
    wr(0, 2); wr(1, 10); wr(2, 4); wr(3, 8); wr(4, 6); wr(5, 0);
    run(40);
    pulse_trig();
    run(30);
    cur_req = "R8";
    wr(1, 3); wr(4, 11);
    run(25);
    pulse_trig();
    run(30);
    wr(10, 3);
    wr(2, 12);
    run(10);
    pulse_trig();
    run(30);

    cur_req = "R9";
    wr(10, 0);
    wr(11, 6'b101010);
    run(50);
    wr(12, 6'b000011);
    run(30);

    cur_req = "R10";
    wr(11, 6'h3F);
    wr(12, 6'b010101);
    run(50);

    cur_req = "R11";
    wr(12, 0);
    wr(9, 0);
    run(40);
    wr(9, 5);
    wr(8, 20);
    run(100);

    cur_req = "R12";
    wr(8, 0);
    run(20);
    chk(peak_stb == 1'b0 && valley_stb == 1'b0, "R12", {peak_stb, valley_stb}, 0);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

endmodule